// File: doc/BRIEF.md
# On-Chip Trace Buffer Analyzer

This block is a small embedded trace memory that works as a logic analyzer inside the chip. After a start request it stores one probe word per clock, such as a group of internal signals or a bus transaction word. It keeps doing so until a stop request arrives. The memory is circular: a long run keeps only the most recent words, and a status flag shows whether the buffer has wrapped at least once.

Trace memories are normally not part of the scan chain, so the stored words leave through a dedicated one-bit serial path. A dump request streams every stored word, oldest first and least significant bit first, while a valid strobe is held high. The same serial path also works in reverse. A load request takes one bit per clock from a serial input and fills the whole array, so a debugger can preload contents and test a hypothesis. Capture, dump and load are mutually exclusive, and requests that arrive while one of them is running are dropped.

Top module: `trace_buffer_analyzer`

## Requirements
- R1: After a synchronous active-low reset, `capturing_o`, `busy_o`, `full_o`, `sdo_valid_o` and `sdo_o` are all low.
- R2: `start_i` while idle makes `capturing_o` high from the next cycle, clears `full_o` and empties the buffer. While capturing, each cycle with `stop_i` low stores the current `probe_i` word.
- R3: `stop_i` while capturing drops `capturing_o` on the next cycle, and the probe word present in that cycle is not stored.
- R4: Storage is circular with room for DEPTH words. After more than DEPTH samples only the last DEPTH remain. `full_o` rises on the cycle after the DEPTH-th sample since the start and stays high until the next start.
- R5: `dump_start_i` while idle with N>0 stored words holds `sdo_valid_o` and `busy_o` high for N*WIDTH cycles, starting on the next cycle. During those cycles `sdo_o` carries one bit per cycle, words from oldest to newest and each word LSB first. `sdo_o` is low whenever `sdo_valid_o` is low. With N=0 the request is ignored.
- R6: `load_start_i` while idle makes `busy_o` high for DEPTH*WIDTH cycles, starting on the next cycle. In those cycles `sdi_i` is sampled once per cycle, LSB first, filling entries from the first upward. Afterwards `full_o` is high, and a dump returns the loaded words in the order they were loaded.
- R7: While a dump or load runs, no capture takes place, and `start_i`, `dump_start_i` and `load_start_i` are ignored.
- R8: When several requests arrive together in idle, start wins over load, and load wins over dump.
- R9: A dump does not alter the stored contents, so a second dump returns the same words.
- R10: While capturing, `dump_start_i` and `load_start_i` are ignored and capture continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | WIDTH | Word sampled while capturing |
| start_i | input | 1 | Begin a fresh capture |
| stop_i | input | 1 | End the capture |
| dump_start_i | input | 1 | Begin serial dump |
| load_start_i | input | 1 | Begin serial load |
| sdi_i | input | 1 | Serial load data, LSB first |
| sdo_o | output | 1 | Serial dump data, LSB first |
| sdo_valid_o | output | 1 | High while a dump bit is on `sdo_o` |
| capturing_o | output | 1 | Capture in progress |
| busy_o | output | 1 | Dump or load in progress |
| full_o | output | 1 | Buffer has wrapped or been fully loaded |

## Verification
The bench targets the following corner cases.

- **Wrap point.** A capture longer than DEPTH checks the dump start point. A design that started the dump at entry zero would return the newest words ahead of older ones.
- **Stop cycle.** The stop cycle carries a distinct probe value. A design that stored it would show an extra final word.
- **Empty dump.** A dump with nothing stored must leave `sdo_valid_o` low. A design that ignored the empty case would stream a whole buffer of stale bits.
- **Dropped requests.** Requests are pulsed during capture, during load, and together in idle. A design with wrong priority or missing lockout would abandon a capture, restart one in the middle of a load, or pick the wrong operation.

// File: rtl/tbuf_pkg.sv
// Shared types for the trace buffer analyzer.
package tbuf_pkg;
    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_CAPT = 2'd1,
        TB_DUMP = 2'd2,
        TB_LOAD = 2'd3
    } tb_mode_e;
endpackage

// File: rtl/tbuf_mem.sv
// Trace storage: DEPTH words of WIDTH bits.
// One synchronous write port and one asynchronous read port.
// Assumes the controller never writes and reads the same entry in a way that matters.
module tbuf_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] ent [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        // Each entry stores the write data when addressed.
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(e))) ent[e] <= wdata;
        end
    end

    // Combinational read of the selected entry.
    assign rdata = ent[raddr];
endmodule

// File: rtl/tbuf_deser.sv
// Serial-to-parallel converter for the load path.
// Takes one bit per enabled cycle, LSB first.
// word_o is the complete word during the cycle in which the last bit is on sdi.
// Assumes WIDTH >= 4.
module tbuf_deser #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdi,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-2:0] sh;

    // Shift right with the new bit entering at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh <= '0;
        else if (shift_en) sh <= {sdi, sh[WIDTH-2:1]};
    end

    // The current bit completes the word.
    assign word_o = {sdi, sh};
endmodule

// File: rtl/tbuf_ctrl.sv
// Mode sequencer for the trace buffer.
// Owns the capture pointer, the dump/load pointer, the bit counter and the full flag.
// Request priority in idle: start, then load, then dump.
// Assumes DEPTH >= 2 and WIDTH >= 2.
module tbuf_ctrl
    import tbuf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int BW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          dump_req,
    input  logic          load_req,
    output tb_mode_e      mode,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [BW-1:0] bit_idx,
    output logic          cap_we,
    output logic          load_we,
    output logic          full
);
    localparam logic [AW-1:0] LAST_ENT = AW'(DEPTH - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);
    localparam logic [AW:0]   ALL_ENT  = (AW + 1)'(DEPTH);

    logic [AW:0] left;
    logic        last_bit;

    assign last_bit = (bit_idx == LAST_BIT);
    assign cap_we   = (mode == TB_CAPT) && !stop_req;
    assign load_we  = (mode == TB_LOAD) && last_bit;

    // Next entry index, wrapping at DEPTH.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST_ENT) ? '0 : p + 1'b1;
    endfunction

    // Mode transitions and pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= TB_IDLE;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            bit_idx <= '0;
            left    <= '0;
            full    <= 1'b0;
        end else begin
            unique case (mode)
                TB_IDLE: begin
                    if (start_req) begin
                        mode   <= TB_CAPT;
                        wr_ptr <= '0;
                        full   <= 1'b0;
                    end else if (load_req) begin
                        mode    <= TB_LOAD;
                        rd_ptr  <= '0;
                        bit_idx <= '0;
                    end else if (dump_req && (full || wr_ptr != '0)) begin
                        mode    <= TB_DUMP;
                        rd_ptr  <= full ? wr_ptr : '0;
                        left    <= full ? ALL_ENT : {1'b0, wr_ptr};
                        bit_idx <= '0;
                    end
                end
                TB_CAPT: begin
                    if (stop_req) begin
                        mode <= TB_IDLE;
                    end else begin
                        wr_ptr <= nxt(wr_ptr);
                        if (wr_ptr == LAST_ENT) full <= 1'b1;
                    end
                end
                TB_DUMP: begin
                    if (last_bit) begin
                        bit_idx <= '0;
                        rd_ptr  <= nxt(rd_ptr);
                        left    <= left - 1'b1;
                        if (left == (AW + 1)'(1)) mode <= TB_IDLE;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                TB_LOAD: begin
                    if (last_bit) begin
                        bit_idx <= '0;
                        rd_ptr  <= nxt(rd_ptr);
                        if (rd_ptr == LAST_ENT) begin
                            mode   <= TB_IDLE;
                            full   <= 1'b1;
                            wr_ptr <= '0;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: mode <= TB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trace_buffer_analyzer.sv
// On-chip trace buffer with circular capture, serial dump and serial load.
// Captures probe_i each cycle while running. Dumps oldest-to-newest, LSB first.
// Loads DEPTH words from sdi_i, LSB first.
// Assumes the request inputs are synchronous to clk.
module trace_buffer_analyzer
    import tbuf_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] probe_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             dump_start_i,
    input  logic             load_start_i,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic             sdo_valid_o,
    output logic             capturing_o,
    output logic             busy_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(WIDTH);

    tb_mode_e         mode;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [BW-1:0]    bit_idx;
    logic             cap_we, load_we;
    logic [WIDTH-1:0] ld_word, rdata, wdata;
    logic [AW-1:0]    waddr;

    tbuf_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_i),
        .stop_req  (stop_i),
        .dump_req  (dump_start_i),
        .load_req  (load_start_i),
        .mode      (mode),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .bit_idx   (bit_idx),
        .cap_we    (cap_we),
        .load_we   (load_we),
        .full      (full_o)
    );

    tbuf_deser #(.WIDTH(WIDTH)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (mode == TB_LOAD),
        .sdi      (sdi_i),
        .word_o   (ld_word)
    );

    // Write source: the probe while capturing, the assembled word while loading.
    assign wdata = cap_we ? probe_i : ld_word;
    assign waddr = cap_we ? wr_ptr : rd_ptr;

    tbuf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (cap_we | load_we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rd_ptr),
        .rdata (rdata)
    );

    // Status and serial output.
    assign capturing_o = (mode == TB_CAPT);
    assign sdo_valid_o = (mode == TB_DUMP);
    assign busy_o      = (mode == TB_DUMP) || (mode == TB_LOAD);
    assign sdo_o       = sdo_valid_o && rdata[bit_idx];
endmodule

// File: rtl/tbuf_chk.sv
// Port-level property checker for trace_buffer_analyzer, attached with bind.
module tbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic dump_start_i,
    input logic load_start_i,
    input logic sdo_o,
    input logic sdo_valid_o,
    input logic capturing_o,
    input logic busy_o,
    input logic full_o
);
    logic idle;
    assign idle = !capturing_o && !busy_o;

    a_r2_start_enters_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_i) |=> (capturing_o && !full_o));

    a_r3_stop_ends_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing_o && stop_i) |=> !capturing_o);

    a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !(idle && start_i)) |=> full_o);

    a_r5_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_valid_o |-> !sdo_o);

    a_r5_valid_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_valid_o |-> busy_o);

    a_r7_exclusive_modes: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capturing_o, busy_o}));

    a_r7_no_capture_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !capturing_o);

    a_r8_load_over_dump: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && load_start_i && !start_i) |=> (busy_o && !sdo_valid_o));

    a_r10_capture_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing_o && !stop_i) |=> capturing_o);
endmodule

bind trace_buffer_analyzer tbuf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .dump_start_i (dump_start_i),
    .load_start_i (load_start_i),
    .sdo_o        (sdo_o),
    .sdo_valid_o  (sdo_valid_o),
    .capturing_o  (capturing_o),
    .busy_o       (busy_o),
    .full_o       (full_o)
);

// File: tb/sim_trace_buffer_analyzer.sv
// Bench: behavioural reference model compared every clock, plus directed dump checks.
module sim_trace_buffer_analyzer;
    localparam int W = 8;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] probe_i = '0;
    logic start_i = 0, stop_i = 0, dump_start_i = 0, load_start_i = 0, sdi_i = 0;
    logic sdo_o, sdo_valid_o, capturing_o, busy_o, full_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    trace_buffer_analyzer #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .start_i(start_i), .stop_i(stop_i),
        .dump_start_i(dump_start_i), .load_start_i(load_start_i), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_valid_o(sdo_valid_o), .capturing_o(capturing_o),
        .busy_o(busy_o), .full_o(full_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 capture, 2 dump, 3 load
    int        m_mode = 0;
    logic [W-1:0] m_q[$];
    bit        m_bits[$];
    logic [W-1:0] m_lq[$];
    logic [W-1:0] m_lw;
    int        m_cnt = 0, m_lb = 0;
    bit        m_full = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_q.delete(); m_bits.delete(); m_full = 0; m_cnt = 0;
        end else begin
            case (m_mode)
                0: if (start_i) begin
                       m_mode = 1; m_q.delete(); m_full = 0; m_cnt = 0;
                   end else if (load_start_i) begin
                       m_mode = 3; m_lb = 0; m_lq.delete(); m_lw = '0;
                   end else if (dump_start_i && m_q.size() > 0) begin
                       m_mode = 2; m_bits.delete();
                       foreach (m_q[k]) for (int b = 0; b < W; b++) m_bits.push_back(m_q[k][b]);
                   end
                1: if (stop_i) m_mode = 0;
                   else begin
                       m_q.push_back(probe_i); m_cnt++;
                       if (m_q.size() > D) void'(m_q.pop_front());
                       if (m_cnt >= D) m_full = 1;
                   end
                2: begin
                       void'(m_bits.pop_front());
                       if (m_bits.size() == 0) m_mode = 0;
                   end
                default: begin
                       m_lw[m_lb % W] = sdi_i; m_lb++;
                       if (m_lb % W == 0) m_lq.push_back(m_lw);
                       if (m_lb == D * W) begin m_q = m_lq; m_full = 1; m_mode = 0; end
                   end
            endcase
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(capturing_o == (m_mode == 1), "R2/R3/R10 capturing_o", capturing_o, m_mode == 1);
            chk(busy_o == (m_mode >= 2), "R7 busy_o", busy_o, m_mode >= 2);
            chk(full_o == m_full, "R4 full_o", full_o, m_full);
            chk(sdo_valid_o == (m_mode == 2), "R5 sdo_valid_o", sdo_valid_o, m_mode == 2);
            chk(sdo_o == ((m_mode == 2) ? m_bits[0] : 1'b0), "R5 sdo_o", sdo_o,
                (m_mode == 2) ? m_bits[0] : 1'b0);
        end
    end

    logic [W-1:0] got[$];
    logic [W-1:0] exp_q[$];

    // Capture n words base+i; optionally poke dump/load requests mid-capture (R10).
    task automatic capture(input int n, input logic [W-1:0] base, input bit poke);
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        for (int i = 0; i < n; i++) begin
            probe_i = base + W'(i);
            dump_start_i = poke && (i == 2);
            load_start_i = poke && (i == 3);
            @(negedge clk);
        end
        dump_start_i = 0; load_start_i = 0;
        stop_i = 1; probe_i = 8'hEE;   // R3: this word must not be stored
        @(negedge clk); stop_i = 0;
    endtask

    task automatic do_dump();
        logic [W-1:0] w;
        int b, guard;
        got.delete(); b = 0; guard = 0; w = '0;
        @(negedge clk); dump_start_i = 1;
        @(negedge clk); dump_start_i = 0;
        while (sdo_valid_o && guard < D * W + 4) begin
            w[b] = sdo_o; b++; guard++;
            if (b == W) begin got.push_back(w); b = 0; end
            @(negedge clk);
        end
    endtask

    task automatic cmp_dump(input string tag);
        chk(got.size() == exp_q.size(), {tag, " word count"}, got.size(), exp_q.size());
        foreach (exp_q[k])
            if (k < got.size()) chk(got[k] == exp_q[k], {tag, " word"}, got[k], exp_q[k]);
    endtask

    task automatic do_load(input bit poke_start, input bit poke_dump);
        @(negedge clk); load_start_i = 1; dump_start_i = poke_dump;
        @(negedge clk); load_start_i = 0; dump_start_i = 0;
        for (int w = 0; w < D; w++)
            for (int b = 0; b < W; b++) begin
                sdi_i = exp_q[w][b];
                start_i = poke_start && (w == 3) && (b == 0);   // R7: ignored
                @(negedge clk);
            end
        start_i = 0; sdi_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!capturing_o && !busy_o && !full_o && !sdo_valid_o && !sdo_o, "R1 reset outputs",
            {capturing_o, busy_o, full_o, sdo_valid_o, sdo_o}, 0);
        rst_n = 1;

        // R2, R3, R5: partial capture then dump
        capture(5, 8'h10, 0);
        chk(full_o == 0, "R4 partial not full", full_o, 0);
        exp_q.delete(); for (int i = 0; i < 5; i++) exp_q.push_back(8'h10 + W'(i));
        do_dump(); cmp_dump("R5 partial dump");
        // R9: repeat dump unchanged
        do_dump(); cmp_dump("R9 repeat dump");

        // R4: wrap, oldest first
        capture(20, 8'h40, 0);
        chk(full_o == 1, "R4 full after wrap", full_o, 1);
        exp_q.delete(); for (int i = 4; i < 20; i++) exp_q.push_back(8'h40 + W'(i));
        do_dump(); cmp_dump("R4 wrapped dump");

        // R6, R7: load with a start pulse mid-load
        exp_q.delete(); for (int i = 0; i < D; i++) exp_q.push_back(8'hA5 ^ W'(i * 7));
        do_load(1, 0);
        chk(full_o == 1 && !capturing_o, "R7 start ignored in load", {full_o, capturing_o}, 2);
        do_dump(); cmp_dump("R6 loaded dump");

        // R10: dump/load pokes during capture
        capture(6, 8'h70, 1);
        exp_q.delete(); for (int i = 0; i < 6; i++) exp_q.push_back(8'h70 + W'(i));
        do_dump(); cmp_dump("R10 capture kept");

        // R8: start beats load
        @(negedge clk); start_i = 1; load_start_i = 1;
        @(negedge clk); start_i = 0; load_start_i = 0;
        chk(capturing_o && !busy_o, "R8 start over load", {capturing_o, busy_o}, 2);
        probe_i = 8'h33; @(negedge clk);
        stop_i = 1; @(negedge clk); stop_i = 0;
        exp_q.delete(); exp_q.push_back(8'h33);
        do_dump(); cmp_dump("R8 single word");

        // R8: load beats dump
        exp_q.delete(); for (int i = 0; i < D; i++) exp_q.push_back(W'(i * 13 + 1));
        do_load(0, 1);
        do_dump(); cmp_dump("R8 load over dump");

        // R5: empty dump ignored
        capture(0, 8'h00, 0);
        @(negedge clk); dump_start_i = 1;
        @(negedge clk); dump_start_i = 0;
        chk(!sdo_valid_o && !busy_o, "R5 empty dump ignored", {sdo_valid_o, busy_o}, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule